// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is an up-counter whose progress can be governed by an external or neighbouring trigger. One of seven trigger sources is chosen by a select code: four internal triggers from other timers, a both-edges detector on input 1, input 1 itself, or input 2. Rising edges are found by comparing the selected trigger with its value one clock earlier. A slave-mode code then decides how the trigger acts on the counter. It can clear the counter, gate its clock, start it, step it once per edge, or clear and start it in a single step.

The counter counts from zero up to a programmable limit, then returns to zero and raises an update pulse. Every detected trigger edge is passed on to downstream timers as a one-cycle pulse. A delay option holds both the local action and that outgoing pulse back by one clock, so that this timer and the timers it drives respond to the same event on the same edge. Mode, source, delay and limit are plain configuration inputs.

Top module: `tmr_slave_ctl`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `update_evt` and `trig_out` are 0.
- R2: With `slave_mode` 0, and with any code other than 4 to 8 (for example 9), `count` advances by one per clock while `cnt_en` is 1 and holds while it is 0. A trigger edge has no effect on `count` in these modes.
- R3: When `count` equals `reload` and would advance, it becomes 0 instead. `update_evt` is 1 in the following cycle. In all other cases `update_evt` is 0, except as required by R4 and R8.
- R4: With `slave_mode` 4, the clock edge that sees a trigger rising edge sets `count` to 0 and makes `update_evt` 1 for one cycle. At other times the counter behaves as in R2.
- R5: With `slave_mode` 5, `count` advances only on clocks where `cnt_en` is 1 and the trigger level is 1. When the level drops, `count` holds its value and is not cleared.
- R6: With `slave_mode` 6, a trigger rising edge starts the counter without changing `count`. The counter then advances on every following clock regardless of `cnt_en` or of the trigger level, until the mode is changed.
- R7: With `slave_mode` 7 and `cnt_en` 1, `count` advances by exactly one per trigger rising edge and holds otherwise.
- R8: With `slave_mode` 8, the counter is stopped until a trigger rising edge arrives. That edge sets `count` to 0, makes `update_evt` 1 and starts the counter, which then runs as in R6.
- R9: `trig_sel` 0 to 3 selects `itr[0]` to `itr[3]`, 4 selects the input-1 edge detector, 5 selects `tin1` and 6 selects `tin2`. Code 7 selects a constant 0, so `trig_out` stays 0.
- R10: The input-1 edge detector produces a one-cycle pulse on every change of `tin1`, rising or falling. In mode 7, each change of `tin1` therefore advances `count` by one.
- R11: Every trigger rising edge, in any slave mode, makes `trig_out` 1 for exactly one cycle. This happens in the same cycle in which the local effect appears on `count`.
- R12: With `ms_delay` 1, the local effect of a trigger edge and the `trig_out` pulse both appear one clock later than with `ms_delay` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable for modes 0, 4, 5, 7 and reserved codes |
| slave_mode | input | 4 | Slave behaviour code (0, 4 to 8; others act as 0) |
| trig_sel | input | 3 | Trigger source code |
| ms_delay | input | 1 | Delay trigger effect and `trig_out` by one clock |
| itr | input | 4 | Internal triggers from other timers |
| tin1 | input | 1 | Conditioned timer input 1 |
| tin2 | input | 1 | Conditioned timer input 2 |
| reload | input | CNT_W | Last count value before wrap |
| count | output | CNT_W | Counter value |
| update_evt | output | 1 | One-cycle update pulse on wrap or trigger clear |
| trig_out | output | 1 | One-cycle pulse per detected trigger edge |

## Verification
Internal state shows up at the ports within one clock, and with `ms_delay` set within two. If the previous-trigger register is wrong, the clear lands a cycle early or late, or `trig_out` fires while the trigger is held high. If the run flag is wrong, modes 6 and 8 start on their own or fail to start, and `count` moves a cycle later than expected. If the edge-detector history is wrong, mode 7 counts half or double the number of `tin1` changes.

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [3:0]       slave_mode,
  input  logic [2:0]       trig_sel,
  input  logic             ms_delay,
  input  logic [3:0]       itr,
  input  logic             tin1,
  input  logic             tin2,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             update_evt,
  output logic             trig_out
);

  logic tin1_q, trg, trg_q, rise, ev_d, ev, lvl, run;
  logic m_clr, m_gate, m_start, m_ext, m_comb;
  logic adv, clr, wrap;

  always_comb begin
    case (trig_sel)
      3'd0, 3'd1, 3'd2, 3'd3: trg = itr[trig_sel[1:0]];
      3'd4:                   trg = tin1 ^ tin1_q;
      3'd5:                   trg = tin1;
      3'd6:                   trg = tin2;
      default:                trg = 1'b0;
    endcase
  end

  assign rise = trg & ~trg_q;
  assign ev   = ms_delay ? ev_d  : rise;
  assign lvl  = ms_delay ? trg_q : trg;

  assign m_clr   = (slave_mode == 4'd4);
  assign m_gate  = (slave_mode == 4'd5);
  assign m_start = (slave_mode == 4'd6);
  assign m_ext   = (slave_mode == 4'd7);
  assign m_comb  = (slave_mode == 4'd8);

  always_comb begin
    if (m_start || m_comb) adv = run;
    else if (m_gate)       adv = cnt_en & lvl;
    else if (m_ext)        adv = cnt_en & ev;
    else                   adv = cnt_en;
  end

  assign clr  = (m_clr | m_comb) & ev;
  assign wrap = adv & (count == reload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tin1_q     <= 1'b0;
      trg_q      <= 1'b0;
      ev_d       <= 1'b0;
      run        <= 1'b0;
      trig_out   <= 1'b0;
      update_evt <= 1'b0;
      count      <= '0;
    end else begin
      tin1_q     <= tin1;
      trg_q      <= trg;
      ev_d       <= rise;
      run        <= (m_start | m_comb) & (run | ev);
      trig_out   <= ev;
      update_evt <= clr | wrap;
      if (clr || wrap) count <= '0;
      else if (adv)    count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_slave_ctl_chk.sv
module tmr_slave_ctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [3:0]       slave_mode,
  input logic [2:0]       trig_sel,
  input logic             ms_delay,
  input logic [3:0]       itr,
  input logic [CNT_W-1:0] count,
  input logic             update_evt,
  input logic             trig_out
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !update_evt && !trig_out));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 4'd0 && !cnt_en) |=> $stable(count));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 4'd4 && !ms_delay && trig_sel == 3'd0 && $stable(trig_sel)
     && itr[0] && !$past(itr[0])) |=> (count == '0 && update_evt));

  a_r5_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 4'd5 && !ms_delay && trig_sel == 3'd0 && !itr[0])
    |=> $stable(count));

  a_r9_none_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 3'd7 && !ms_delay) |=> !trig_out);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

endmodule

bind tmr_slave_ctl tmr_slave_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slave_mode(slave_mode),
  .trig_sel(trig_sel), .ms_delay(ms_delay), .itr(itr), .count(count),
  .update_evt(update_evt), .trig_out(trig_out)
);

// File: tb/tmr_slave_ctl_test.sv
`timescale 1ns/1ps
module tmr_slave_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n, cnt_en, ms_delay, tin1, tin2;
  logic [3:0]  slave_mode, itr;
  logic [2:0]  trig_sel;
  logic [15:0] reload, count;
  logic        update_evt, trig_out;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tmr_slave_ctl #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slave_mode(slave_mode),
    .trig_sel(trig_sel), .ms_delay(ms_delay), .itr(itr), .tin1(tin1),
    .tin2(tin2), .reload(reload), .count(count), .update_evt(update_evt),
    .trig_out(trig_out)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_en = 1'b0; slave_mode = 4'd0; trig_sel = 3'd0;
    ms_delay = 1'b0; itr = 4'd0; tin1 = 1'b0; tin2 = 1'b0; reload = 16'd100;
    tick(2);
    check("R1 count in reset", count, 0);
    check("R1 update in reset", update_evt, 0);
    check("R1 trig_out in reset", trig_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_free_run();
    do_reset();
    reload = 16'd5; cnt_en = 1'b1;
    tick(5);
    check("R2 count after 5", count, 5);
    check("R3 no update before wrap", update_evt, 0);
    tick();
    check("R3 wrap to zero", count, 0);
    check("R3 update on wrap", update_evt, 1);
    tick();
    check("R3 update one cycle", update_evt, 0);
    cnt_en = 1'b0;
    tick(3);
    check("R2 hold when disabled", count, 1);
    slave_mode = 4'd9; cnt_en = 1'b1;
    tick(2);
    check("R2 reserved mode counts", count, 3);
    itr[0] = 1'b1;
    tick();
    check("R2 reserved mode ignores edge", count, 4);
    check("R11 trig_out in reserved mode", trig_out, 1);
  endtask

  task automatic t_reset_mode();
    do_reset();
    slave_mode = 4'd4; cnt_en = 1'b1;
    tick(10);
    check("R4 count before edge", count, 10);
    itr[0] = 1'b1;
    tick();
    check("R4 cleared on edge", count, 0);
    check("R4 update on edge", update_evt, 1);
    check("R11 trig_out with effect", trig_out, 1);
    tick();
    check("R4 runs after clear", count, 1);
    check("R11 trig_out one cycle", trig_out, 0);
    tick(3);
    check("R4 level alone no clear", count, 4);
  endtask

  task automatic t_gated();
    do_reset();
    slave_mode = 4'd5; trig_sel = 3'd5; cnt_en = 1'b1;
    tick(3);
    check("R5 low gate holds", count, 0);
    tin1 = 1'b1;
    tick(4);
    check("R5 high gate counts", count, 4);
    tin1 = 1'b0;
    tick(3);
    check("R5 stop without clear", count, 4);
    tin1 = 1'b1;
    tick(2);
    check("R5 resumes", count, 6);
  endtask

  task automatic t_trigger();
    do_reset();
    slave_mode = 4'd6; trig_sel = 3'd6;
    tick(3);
    check("R6 waits for edge", count, 0);
    tin2 = 1'b1;
    tick();
    check("R6 start keeps value", count, 0);
    check("R9 input 2 selected", trig_out, 1);
    tick(3);
    check("R6 running", count, 3);
    tin2 = 1'b0;
    tick(2);
    check("R6 stop not controlled", count, 5);
  endtask

  task automatic t_ext_clock();
    do_reset();
    slave_mode = 4'd7; trig_sel = 3'd1; cnt_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      itr[1] = 1'b1; tick();
      itr[1] = 1'b0; tick();
    end
    check("R7 one step per edge", count, 4);
    itr[1] = 1'b1;
    tick(4);
    check("R7 high level no steps", count, 5);
  endtask

  task automatic t_edge_det();
    do_reset();
    slave_mode = 4'd7; trig_sel = 3'd4; cnt_en = 1'b1;
    tin1 = 1'b1; tick(3);
    tin1 = 1'b0; tick(3);
    tin1 = 1'b1; tick(3);
    check("R10 both transitions counted", count, 3);
    do_reset();
    slave_mode = 4'd7; trig_sel = 3'd5; cnt_en = 1'b1;
    tin1 = 1'b1; tick(3);
    tin1 = 1'b0; tick(3);
    tin1 = 1'b1; tick(3);
    check("R10 plain input rising only", count, 2);
  endtask

  task automatic t_combined();
    do_reset();
    cnt_en = 1'b1;
    tick(7);
    slave_mode = 4'd8; trig_sel = 3'd2;
    tick(2);
    check("R8 stopped until edge", count, 7);
    itr[2] = 1'b1;
    tick();
    check("R8 cleared on edge", count, 0);
    check("R8 update on edge", update_evt, 1);
    tick(3);
    check("R8 started", count, 3);
  endtask

  task automatic t_ms_delay();
    do_reset();
    slave_mode = 4'd4; trig_sel = 3'd3; ms_delay = 1'b1; cnt_en = 1'b1;
    tick(10);
    itr[3] = 1'b1;
    tick();
    check("R12 no effect yet", count, 11);
    check("R12 no trig_out yet", trig_out, 0);
    tick();
    check("R12 delayed clear", count, 0);
    check("R12 delayed update", update_evt, 1);
    check("R12 delayed trig_out", trig_out, 1);
    tick();
    check("R12 trig_out one cycle", trig_out, 0);
  endtask

  task automatic t_reserved_sel();
    do_reset();
    slave_mode = 4'd4; trig_sel = 3'd7; cnt_en = 1'b1;
    tick(2);
    for (int i = 0; i < 6; i++) begin
      itr = ~itr; tin1 = ~tin1; tin2 = ~tin2;
      tick();
      check("R9 reserved select no trig_out", trig_out, 0);
    end
    check("R9 reserved select no clear", count, 8);
  endtask

  initial begin
    t_free_run();
    t_reset_mode();
    t_gated();
    t_trigger();
    t_ext_clock();
    t_edge_det();
    t_combined();
    t_ms_delay();
    t_reserved_sel();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule